// File: doc/BRIEF.md
# Auto-Increment Transfer Buffer Port

This block is a 512-byte staging buffer between a 32-bit register port and the byte stream of a serial flash sequencer. Software uses three registers. A control register holds a direction bit, an auto-step bit and a starting word pointer. Through a single data register, software then pushes words into the buffer (fill) or pulls words out of it (drain). When auto-step is set, each accepted data access advances the word pointer by one, so a whole chunk moves through one address.

The sequencer side works in bytes. A separate start register holds the byte address where the sequencer's data phase begins, and software normally sets it to 0 before each chunk. A start strobe loads the sequencer's byte pointer from that register. Each byte read, which feeds data-out, or byte write, which captures data-in, then advances the pointer. Bytes are packed little-endian inside words, so a chunk whose length is not a multiple of four ends in one word in which only the low-order bytes are meaningful.

Top module: `xfer_buf_port`

## Requirements
- R1: After reset, the control register reads 0: drain direction, auto-step off, pointer 0. The start register also reads 0, and `reg_rvalid_o` is low.
- R2: `reg_addr_i` selects a register: 0 is control, 1 is data, 2 is the sequencer start register (a byte address held in bits 8:0), and 3 reads 0 and ignores writes. Control bit 31 is the direction (1 = fill, 0 = drain) and bit 30 is auto-step. Bits 7:0 load the word pointer, using only the low 7 bits for 128 words. A control read returns the direction, auto-step and current pointer in those positions, with all other bits 0.
- R3: In fill direction, a data write stores the 32-bit word at the word pointer. With auto-step on, the pointer then advances by one; with auto-step off, it holds.
- R4: In drain direction, a data read returns the word at the pointer one cycle later. The pointer advances after the word is captured, but only when auto-step is on.
- R5: A data write in drain direction changes neither storage nor the pointer. A data read in fill direction returns 0 and leaves the pointer unchanged.
- R6: The word pointer wraps from word 127 to word 0.
- R7: Byte k of the buffer is held in word k/4, bits 8*(k%4)+7 down to 8*(k%4).
- R8: `seq_start_i` loads the byte pointer from the start register. A `seq_rd_i` returns the addressed byte on `seq_rdata_o` one cycle later and advances the pointer. A `seq_wr_i` stores `seq_wdata_i` and advances the pointer. The byte pointer wraps from 511 to 0.
- R9: When the sequencer writes a byte count that is not a multiple of 4, the final word takes the new bytes in its low-order positions. Its upper bytes keep their previous content.
- R10: When `seq_start_i` is asserted together with `seq_rd_i` or `seq_wr_i`, only the load takes place. No byte is written and the pointer does not advance.
- R11: `reg_rvalid_o` is high exactly in the cycle after each cycle with `reg_re_i` asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after reg_re_i |
| seq_start_i | input | 1 | Load sequencer byte pointer from start register |
| seq_rd_i | input | 1 | Sequencer byte read (data-out) |
| seq_wr_i | input | 1 | Sequencer byte write (data-in) |
| seq_wdata_i | input | 8 | Sequencer write byte |
| seq_rdata_o | output | 8 | Sequencer read byte, one cycle after seq_rd_i |

## Verification
The bench drives both pointers across their wrap points. A design that failed to wrap at word 127 or at byte 511 would return data from the wrong word and leave the word 0 bytes untouched. It checks that accesses against the selected direction are blocked: a design that gated only storage and not the pointer would shift every later drain by one word. A partial sequencer write followed by a host drain exposes wrong byte-lane order and whole-word clobbering of the upper bytes. A start strobe issued in the same cycle as a byte write shows whether the write leaked through.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_DATA  = 2'd1,
    SEL_START = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_DIR_BIT  = 31;
  localparam int unsigned CTRL_AUTO_BIT = 30;
  localparam int unsigned PTR_FIELD_W   = 8;
  localparam int unsigned REG_W         = 32;
endpackage

// File: rtl/tbp_lane.sv
// One byte lane of the buffer: one write port, two registered read ports.
module tbp_lane #(
  parameter int unsigned WORDS = 128,
  parameter int unsigned AW    = 7
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic          a_re_i,
  input  logic [AW-1:0] a_addr_i,
  output logic [7:0]    a_rdata_o,
  input  logic          b_re_i,
  input  logic [AW-1:0] b_addr_i,
  output logic [7:0]    b_rdata_o
);
  logic [7:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i)   mem_q[waddr_i] <= wdata_i;
    if (a_re_i) a_rdata_o      <= mem_q[a_addr_i];
    if (b_re_i) b_rdata_o      <= mem_q[b_addr_i];
  end
endmodule

// File: rtl/tbp_host_port.sv
module tbp_host_port
  import tbp_pkg::*;
#(
  parameter int unsigned WPTR_W = 7,
  parameter int unsigned BPTR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic              fill_we_o,
  output logic              drain_re_o,
  output logic [WPTR_W-1:0] wptr_o,
  output logic [BPTR_W-1:0] start_o,
  output logic              dir_o,
  output logic              auto_o,
  output logic [REG_W-1:0]  csr_rdata_o,
  output logic              data_sel_o,
  output logic              rvalid_o
);
  reg_sel_e          sel;
  logic              dir_q, auto_q, step;
  logic [WPTR_W-1:0] wptr_q;
  logic [BPTR_W-1:0] start_q;
  logic [REG_W-1:0]  ctrl_view, csr_d;
  logic              unused_wdata;

  assign sel          = reg_sel_e'(reg_addr_i);
  assign unused_wdata = ^reg_wdata_i;

  // direction gates the data register
  assign fill_we_o  = reg_we_i && sel == SEL_DATA && dir_q;
  assign drain_re_o = reg_re_i && sel == SEL_DATA && !dir_q;
  assign step       = (fill_we_o || drain_re_o) && auto_q;

  always_comb begin
    ctrl_view                = '0;
    ctrl_view[CTRL_DIR_BIT]  = dir_q;
    ctrl_view[CTRL_AUTO_BIT] = auto_q;
    ctrl_view[WPTR_W-1:0]    = wptr_q;
  end

  always_comb begin
    case (sel)
      SEL_CTRL:  csr_d = ctrl_view;
      SEL_START: csr_d = REG_W'(start_q);
      default:   csr_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= 1'b0;
      auto_q <= 1'b0;
      wptr_q <= '0;
    end else if (reg_we_i && sel == SEL_CTRL) begin
      dir_q  <= reg_wdata_i[CTRL_DIR_BIT];
      auto_q <= reg_wdata_i[CTRL_AUTO_BIT];
      wptr_q <= reg_wdata_i[WPTR_W-1:0];
    end else if (step) begin
      wptr_q <= wptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           start_q <= '0;
    else if (reg_we_i && sel == SEL_START) start_q <= reg_wdata_i[BPTR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o    <= 1'b0;
      data_sel_o  <= 1'b0;
      csr_rdata_o <= '0;
    end else begin
      rvalid_o   <= reg_re_i;
      data_sel_o <= drain_re_o;
      if (reg_re_i) csr_rdata_o <= csr_d;
    end
  end

  assign wptr_o  = wptr_q;
  assign start_o = start_q;
  assign dir_o   = dir_q;
  assign auto_o  = auto_q;
endmodule

// File: rtl/tbp_seq_port.sv
module tbp_seq_port #(
  parameter int unsigned BPTR_W = 9,
  parameter int unsigned LANE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BPTR_W-1:0] start_addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [BPTR_W-1:0] bptr_o,
  output logic              rd_go_o,
  output logic              wr_go_o,
  output logic [LANE_W-1:0] lane_q_o
);
  logic [BPTR_W-1:0] bptr_q;

  // a load takes the cycle; a coincident access is dropped
  assign rd_go_o = rd_i && !start_i;
  assign wr_go_o = wr_i && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  bptr_q <= '0;
    else if (start_i)             bptr_q <= start_addr_i;
    else if (rd_go_o || wr_go_o)  bptr_q <= bptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lane_q_o <= '0;
    else if (rd_go_o) lane_q_o <= bptr_q[LANE_W-1:0];
  end

  assign bptr_o = bptr_q;
endmodule

// File: rtl/xfer_buf_port.sv
module xfer_buf_port
  import tbp_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             reg_rvalid_o,
  input  logic             seq_start_i,
  input  logic             seq_rd_i,
  input  logic             seq_wr_i,
  input  logic [7:0]       seq_wdata_i,
  output logic [7:0]       seq_rdata_o
);
  localparam int unsigned LANES  = REG_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned WORDS  = BUF_BYTES / LANES;
  localparam int unsigned WPTR_W = $clog2(WORDS);
  localparam int unsigned BPTR_W = $clog2(BUF_BYTES);

  logic              fill_we, drain_re, dir_q, auto_q, data_sel_q;
  logic [WPTR_W-1:0] wptr;
  logic [BPTR_W-1:0] start_q, bptr;
  logic [REG_W-1:0]  csr_rdata;
  logic              seq_rd_go, seq_wr_go;
  logic [LANE_W-1:0] seq_lane_q;
  logic [REG_W-1:0]  host_word;
  logic [7:0]        seq_byte [LANES];

  tbp_host_port #(.WPTR_W(WPTR_W), .BPTR_W(BPTR_W)) i_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_re_i    (reg_re_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .fill_we_o   (fill_we),
    .drain_re_o  (drain_re),
    .wptr_o      (wptr),
    .start_o     (start_q),
    .dir_o       (dir_q),
    .auto_o      (auto_q),
    .csr_rdata_o (csr_rdata),
    .data_sel_o  (data_sel_q),
    .rvalid_o    (reg_rvalid_o)
  );

  tbp_seq_port #(.BPTR_W(BPTR_W), .LANE_W(LANE_W)) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (seq_start_i),
    .start_addr_i (start_q),
    .rd_i         (seq_rd_i),
    .wr_i         (seq_wr_i),
    .bptr_o       (bptr),
    .rd_go_o      (seq_rd_go),
    .wr_go_o      (seq_wr_go),
    .lane_q_o     (seq_lane_q)
  );

  // little-endian lanes: lane g holds byte offset g of each word
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic              lane_we;
    logic [WPTR_W-1:0] lane_waddr;
    logic [7:0]        lane_wdata;
    logic              seq_hit;

    assign seq_hit    = seq_wr_go && bptr[LANE_W-1:0] == LANE_W'(g);
    assign lane_we    = fill_we || seq_hit;
    assign lane_waddr = fill_we ? wptr : bptr[BPTR_W-1:LANE_W];
    assign lane_wdata = fill_we ? reg_wdata_i[8*g +: 8] : seq_wdata_i;

    tbp_lane #(.WORDS(WORDS), .AW(WPTR_W)) i_lane (
      .clk_i     (clk_i),
      .we_i      (lane_we),
      .waddr_i   (lane_waddr),
      .wdata_i   (lane_wdata),
      .a_re_i    (drain_re),
      .a_addr_i  (wptr),
      .a_rdata_o (host_word[8*g +: 8]),
      .b_re_i    (seq_rd_go),
      .b_addr_i  (bptr[BPTR_W-1:LANE_W]),
      .b_rdata_o (seq_byte[g])
    );
  end

  assign reg_rdata_o = data_sel_q ? host_word : csr_rdata;
  assign seq_rdata_o = seq_byte[seq_lane_q];
endmodule

// File: rtl/xfer_buf_port_chk.sv
module xfer_buf_port_chk #(
  parameter int unsigned WPTR_W = 7,
  parameter int unsigned BPTR_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic [1:0]        reg_addr_i,
  input logic [31:0]       reg_rdata_o,
  input logic              reg_rvalid_o,
  input logic              seq_start_i,
  input logic              seq_rd_i,
  input logic              seq_wr_i,
  input logic              dir_i,
  input logic              auto_i,
  input logic [WPTR_W-1:0] wptr_i,
  input logic [BPTR_W-1:0] start_i,
  input logic [BPTR_W-1:0] bptr_i
);
  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_i |=> reg_rvalid_o); // R11
  AST_RVALID_ONLY_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_re_i |=> !reg_rvalid_o); // R11
  AST_FILL_STEPS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_re_i && reg_addr_i == 2'd1 && dir_i && auto_i)
    |=> wptr_i == $past(wptr_i) + 1'b1); // R3
  AST_BLOCKED_WRITE_HOLDS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_re_i && reg_addr_i == 2'd1 && !dir_i) |=> $stable(wptr_i)); // R5
  AST_BLOCKED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && !reg_we_i && reg_addr_i == 2'd1 && dir_i) |=> reg_rdata_o == 32'd0); // R5
  AST_SEQ_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_start_i |=> bptr_i == $past(start_i)); // R8
  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seq_start_i && (seq_rd_i || seq_wr_i)) |=> bptr_i == $past(bptr_i) + 1'b1); // R8
endmodule

bind xfer_buf_port xfer_buf_port_chk #(.WPTR_W(WPTR_W), .BPTR_W(BPTR_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_re_i     (reg_re_i),
  .reg_addr_i   (reg_addr_i),
  .reg_rdata_o  (reg_rdata_o),
  .reg_rvalid_o (reg_rvalid_o),
  .seq_start_i  (seq_start_i),
  .seq_rd_i     (seq_rd_i),
  .seq_wr_i     (seq_wr_i),
  .dir_i        (dir_q),
  .auto_i       (auto_q),
  .wptr_i       (wptr),
  .start_i      (start_q),
  .bptr_i       (bptr)
);

// File: tb/test_xfer_buf_port.sv
module test_xfer_buf_port;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 30;

  // {read, reg_addr, data (write value or expected), requirement number}
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 32'hC000_0005, 4'd3},  // R3 fill, auto, ptr 5
    {1'b0, 2'd1, 32'h1122_3344, 4'd3},
    {1'b0, 2'd1, 32'hA5A5_5A5A, 4'd3},
    {1'b1, 2'd0, 32'hC000_0007, 4'd3},  // R3 ptr stepped twice
    {1'b0, 2'd0, 32'h4000_0005, 4'd4},  // R4 drain, auto
    {1'b1, 2'd1, 32'h1122_3344, 4'd4},
    {1'b1, 2'd1, 32'hA5A5_5A5A, 4'd4},
    {1'b1, 2'd0, 32'h4000_0007, 4'd4},
    {1'b0, 2'd0, 32'h0000_0005, 4'd4},  // R4 drain, manual
    {1'b1, 2'd1, 32'h1122_3344, 4'd4},
    {1'b1, 2'd1, 32'h1122_3344, 4'd4},
    {1'b1, 2'd0, 32'h0000_0005, 4'd4},
    {1'b0, 2'd0, 32'h4000_0005, 4'd5},  // R5 write in drain blocked
    {1'b0, 2'd1, 32'hDEAD_BEEF, 4'd5},
    {1'b1, 2'd0, 32'h4000_0005, 4'd5},
    {1'b1, 2'd1, 32'h1122_3344, 4'd5},
    {1'b0, 2'd0, 32'hC000_0005, 4'd5},  // R5 read in fill blocked
    {1'b1, 2'd1, 32'h0000_0000, 4'd5},
    {1'b1, 2'd0, 32'hC000_0005, 4'd5},
    {1'b0, 2'd0, 32'hC000_00FF, 4'd2},  // R2 bit 7 dropped
    {1'b1, 2'd0, 32'hC000_007F, 4'd2},
    {1'b0, 2'd1, 32'h0BAD_F00D, 4'd6},  // R6 word 127 then wrap
    {1'b1, 2'd0, 32'hC000_0000, 4'd6},
    {1'b0, 2'd0, 32'h4000_007F, 4'd6},
    {1'b1, 2'd1, 32'h0BAD_F00D, 4'd6},
    {1'b1, 2'd0, 32'h4000_0000, 4'd6},
    {1'b0, 2'd3, 32'hFFFF_FFFF, 4'd2},  // R2 unused select
    {1'b1, 2'd3, 32'h0000_0000, 4'd2},
    {1'b0, 2'd2, 32'h0000_1234, 4'd2},  // R2 start keeps 9 bits
    {1'b1, 2'd2, 32'h0000_0034, 4'd2}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        reg_rvalid_o;
  logic        seq_start_i = 1'b0, seq_rd_i = 1'b0, seq_wr_i = 1'b0;
  logic [7:0]  seq_wdata_i = '0;
  logic [7:0]  seq_rdata_o;

  int n_cmp = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xfer_buf_port i_xfer_buf_port (
    .clk_i, .rst_ni, .reg_we_i, .reg_re_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .reg_rvalid_o, .seq_start_i, .seq_rd_i, .seq_wr_i,
    .seq_wdata_i, .seq_rdata_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, logic [31:0] exp, string req);
    @(negedge clk_i);
    reg_re_i = 1'b1; reg_addr_i = a;
    @(negedge clk_i);
    reg_re_i = 1'b0;
    check("R11", 32'(reg_rvalid_o), 32'd1);
    check(req, reg_rdata_o, exp);
  endtask

  task automatic seq_op(logic st, logic rd, logic wr, logic [7:0] d);
    @(negedge clk_i);
    seq_start_i = st; seq_rd_i = rd; seq_wr_i = wr; seq_wdata_i = d;
    @(negedge clk_i);
    seq_start_i = 1'b0; seq_rd_i = 1'b0; seq_wr_i = 1'b0;
  endtask

  task automatic seq_read(logic [7:0] exp, string req);
    seq_op(1'b0, 1'b1, 1'b0, 8'h00);
    check(req, 32'(seq_rdata_o), 32'(exp));
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    check("R1", 32'(reg_rvalid_o), 32'd0);
    reg_read(2'd0, 32'h0, "R1");
    reg_read(2'd2, 32'h0, "R1");

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][38]) reg_read(VEC[i][37:36], VEC[i][35:4], $sformatf("R%0d", VEC[i][3:0]));
      else            reg_write(VEC[i][37:36], VEC[i][35:4]);
    end

    // R7 R8: host fills bytes 0..7, sequencer reads bytes 1..5
    reg_write(2'd0, 32'hC000_0000);
    reg_write(2'd1, 32'h0302_0100);
    reg_write(2'd1, 32'h0706_0504);
    reg_write(2'd2, 32'd1);
    seq_op(1'b1, 1'b0, 1'b0, 8'h00);
    for (int k = 1; k <= 5; k++) seq_read(8'(k), "R7");

    // R9 partial final word from sequencer writes
    reg_write(2'd0, 32'hC000_0002);
    reg_write(2'd1, 32'hCCCC_CCCC);
    reg_write(2'd1, 32'hDDDD_DDDD);
    reg_write(2'd2, 32'd8);
    seq_op(1'b1, 1'b0, 1'b0, 8'h00);
    for (int k = 0; k < 6; k++) seq_op(1'b0, 1'b0, 1'b1, 8'(8'h10 + k));
    reg_write(2'd0, 32'h4000_0002);
    reg_read(2'd1, 32'h1312_1110, "R9");
    reg_read(2'd1, 32'hDDDD_1514, "R9");

    // R8 byte pointer wrap 511 -> 0
    reg_write(2'd2, 32'h1FF);
    seq_op(1'b1, 1'b0, 1'b0, 8'h00);
    seq_op(1'b0, 1'b0, 1'b1, 8'hAB);
    seq_op(1'b0, 1'b0, 1'b1, 8'hCD);
    reg_write(2'd0, 32'h4000_007F);
    reg_read(2'd1, 32'hABAD_F00D, "R8");
    reg_read(2'd1, 32'h0302_01CD, "R8");

    // R10 start with write: write dropped
    reg_write(2'd0, 32'hC000_0004);
    reg_write(2'd1, 32'h4444_4444);
    reg_write(2'd2, 32'd16);
    seq_op(1'b1, 1'b0, 1'b1, 8'h99);
    seq_read(8'h44, "R10");
    reg_write(2'd0, 32'h4000_0004);
    reg_read(2'd1, 32'h4444_4444, "R10");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule